// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Lanes

This block models a single-port synchronous static RAM whose 18-bit word is split into two 9-bit byte lanes. All control and address inputs are captured on the rising clock edge. The exceptions are the output enable, which gates the read data combinationally, and the burst-order and latency selects, which are expected to stay fixed. A cycle starts when one of two active-low address strobes is seen with all three chip enables active. Later cycles either step through a four-beat burst or hold the current address.

The processor-side strobe counts only while the master enable is low, and it wins when both strobes arrive together. Its first cycle is always a read. The controller-side strobe may write on its first cycle. The beat order is either the two low address bits XORed with a beat counter or a linear increment modulo 4. Writes are qualified by a global write enable and, when that is inactive, by a byte-write enable with per-lane selects. Read data leaves after one register stage in flow-through mode or after two in pipelined mode. A sleep input freezes the block without losing memory contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_ni` is low, and after its release until the next cycle starts, `dout_oe_o` is low and the device is deselected, so an advance with no strobe produces no read.
- R2: A controller strobe (`adsc_n_i`=0) with `ce_n_i`=0, `ce1_i`=1 and `ce2_n_i`=0 loads `addr_i` as the burst base, and a write on that same cycle lands at `addr_i`.
- R3: With `ce_n_i`=1, the processor strobe `adsp_n_i` has no effect. With `ce_n_i`=0 and both strobes low, the processor strobe takes priority, so the cycle is a read.
- R4: A strobe seen while `ce1_i`=0 or `ce2_n_i`=1 deselects the device. That cycle writes nothing, and no read data is enabled until a new cycle starts.
- R5: With `order_xor_i`=1, beat k (k=0..3, wrapping) accesses the base address with its two low bits XORed with k. Each cycle with `adv_n_i`=0 and no strobe moves to the next beat.
- R6: With `order_xor_i`=0, beat k accesses the base address with its two low bits replaced by (base low bits + k) mod 4.
- R7: The first cycle of a processor-strobe start is a read, whatever the write enables say.
- R8: `gwe_n_i`=0 writes both lanes. Otherwise, with `bwe_n_i`=0, each lane whose `bw_n_i` bit is 0 is written (bit 0 is lane a, data bits 8:0; bit 1 is lane b, bits 17:9). If no lane is selected, or if `bwe_n_i`=1, the cycle is a read.
- R9: A cycle with no strobe and `adv_n_i`=1 keeps the current address, both for reads and for writes.
- R10: `dout_oe_o` is high only while `oe_n_i`=0 and valid read data is present. It follows `oe_n_i` without a clock edge.
- R11: With `pipe_i`=0, read data appears after the edge that samples the read. With `pipe_i`=1, it appears one edge later.
- R12: While `sleep_i`=1, no read or write takes place and the burst state is frozen. After release, the burst resumes from the held beat, and memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 18 | Write data, lane b in 17:9, lane a in 8:0 |
| dout_o | output | 18 | Read data |
| dout_oe_o | output | 1 | Read data valid and enabled |
| ce_n_i | input | 1 | Master chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_n_i | input | 1 | Chip enable, active low |
| adsp_n_i | input | 1 | Processor-side address strobe, active low |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwe_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | 2 | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low, combinational |
| order_xor_i | input | 1 | Burst order: 1 XOR, 0 linear |
| pipe_i | input | 1 | Read latency: 1 pipelined, 0 flow-through |
| sleep_i | input | 1 | Sleep, freezes the block |

## Verification
The assertions assume that `order_xor_i` and `pipe_i` are held steady within any burst. They also assume that every control input is a clean 0 or 1 at each rising edge. The stimulus changes inputs only 5 ns after a rising edge and changes the static selects only between bursts. It toggles `oe_n_i` mid-cycle solely to show the combinational gating.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int unsigned BEAT_W = 2;

  // low address bits for a given beat of a 4-beat burst
  function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] base,
                                                 input logic [BEAT_W-1:0] cnt,
                                                 input logic              xor_mode);
    return xor_mode ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              gwe_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              order_xor_i,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  wr_be_o,
  output logic              rd_en_o
);
  logic [ADDR_W-1:0] base_q, base_nxt;
  logic [BEAT_W-1:0] cnt_q, cnt_nxt;
  logic              sel_q, sel_nxt;
  logic              adsp_eff, strobe, en_all, start, desel, adv, active, first_p;
  logic [LANES-1:0]  wr_req;

  always_comb begin
    adsp_eff = !adsp_n_i && !ce_n_i;            // master enable gates processor strobe
    strobe   = adsp_eff || !adsc_n_i;
    en_all   = !ce_n_i && ce1_i && !ce2_n_i;
    start    = !sleep_i && strobe && en_all;
    desel    = !sleep_i && strobe && !en_all;
    adv      = !sleep_i && !strobe && sel_q && !adv_n_i;
    first_p  = start && adsp_eff;

    base_nxt = start ? addr_i : base_q;
    cnt_nxt  = start ? '0 : (adv ? cnt_q + 1'b1 : cnt_q);
    sel_nxt  = start ? 1'b1 : (desel ? 1'b0 : sel_q);
    active   = !sleep_i && sel_nxt;

    acc_addr_o = {base_nxt[ADDR_W-1:BEAT_W], beat_lo(base_nxt[BEAT_W-1:0], cnt_nxt, order_xor_i)};

    if (!gwe_n_i)      wr_req = '1;
    else if (!bwe_n_i) wr_req = ~bw_n_i;
    else               wr_req = '0;

    wr_be_o = (active && !first_p) ? wr_req : '0;
    rd_en_o = active && (first_p || (wr_req == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
      sel_q  <= sel_nxt;
    end
  end

  a_r9_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && adsc_n_i && (adsp_n_i || ce_n_i) && adv_n_i)
      |=> ($stable(base_q) && $stable(cnt_q)));

  a_r5_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel_q && adsc_n_i && (adsp_n_i || ce_n_i) && !adv_n_i)
      |=> (cnt_q == $past(cnt_q) + 2'd1));

  a_r4_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adsc_n_i && !ce1_i) |=> !sel_q);

  a_r12_sleep_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(base_q) && $stable(cnt_q) && $stable(sel_q)));

  a_r7_adsp_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adsp_n_i && !ce_n_i && ce1_i && !ce2_n_i) |-> (wr_be_o == '0));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     din_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_vld_o
);
  logic rd_vld_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_be_i[g]) mem_q[addr_i] <= din_i[g*LANE_W +: LANE_W];
      if (rd_en_i)    rd_q          <= mem_q[addr_i];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_en_i;
  end

  assign rd_vld_o = rd_vld_q;

  a_r8_write_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_be_i != '0) |=> !rd_vld_o);
endmodule

// File: rtl/sbsram_outstage.sv
module sbsram_outstage #(
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_i,
  input  logic          oe_n_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_vld_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o
);
  logic [DW-1:0] data2_q;
  logic          vld2_q;

  always_ff @(posedge clk_i) data2_q <= rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld2_q <= 1'b0;
    else         vld2_q <= rd_vld_i;
  end

  assign dout_o    = pipe_i ? data2_q : rd_data_i;
  assign dout_oe_o = !oe_n_i && (pipe_i ? vld2_q : rd_vld_i);   // async gate

  a_r11_pipe_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld2_q |-> $past(rd_vld_i));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     din_i,
  output logic [DW-1:0]     dout_o,
  output logic              dout_oe_o,
  input  logic              ce_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              gwe_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              oe_n_i,
  input  logic              order_xor_i,
  input  logic              pipe_i,
  input  logic              sleep_i
);
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  wr_be;
  logic              rd_en;
  logic [DW-1:0]     rd_data;
  logic              rd_vld;

  sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .ce_n_i, .ce1_i, .ce2_n_i,
    .adsp_n_i, .adsc_n_i, .adv_n_i, .gwe_n_i, .bwe_n_i, .bw_n_i,
    .order_xor_i, .sleep_i,
    .acc_addr_o(acc_addr), .wr_be_o(wr_be), .rd_en_o(rd_en)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .addr_i(acc_addr), .wr_be_i(wr_be), .rd_en_i(rd_en),
    .din_i, .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  sbsram_outstage #(.DW(DW)) u_out (
    .clk_i, .rst_ni, .pipe_i, .oe_n_i, .rd_data_i(rd_data), .rd_vld_i(rd_vld),
    .dout_o, .dout_oe_o
  );

  a_r12_sleep_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (wr_be == '0 && !rd_en));
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [17:0] din_i = '0;
  logic [17:0] dout_o;
  logic        dout_oe_o;
  logic        ce_n_i = 1'b0, ce1_i = 1'b1, ce2_n_i = 1'b0;
  logic        adsp_n_i = 1'b1, adsc_n_i = 1'b1, adv_n_i = 1'b1;
  logic        gwe_n_i = 1'b1, bwe_n_i = 1'b1;
  logic [1:0]  bw_n_i = 2'b11;
  logic        oe_n_i = 1'b0, order_xor_i = 1'b1, pipe_i = 1'b0, sleep_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  sync_burst_sram u_sync_burst_sram (
    .clk_i, .rst_ni, .addr_i, .din_i, .dout_o, .dout_oe_o,
    .ce_n_i, .ce1_i, .ce2_n_i, .adsp_n_i, .adsc_n_i, .adv_n_i,
    .gwe_n_i, .bwe_n_i, .bw_n_i, .oe_n_i, .order_xor_i, .pipe_i, .sleep_i
  );

  // ctl = {adsp_n, adsc_n, adv_n, gwe_n, bwe_n}; ce = {ce_n, ce1, ce2_n}
  typedef struct packed {
    logic [4:0]  ctl;
    logic [1:0]  bw;
    logic [2:0]  ce;
    logic [7:0]  addr;
    logic [17:0] din;
    logic        exp_oe;
    logic [17:0] exp_do;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{5'b10101, 2'b11, 3'b010, 8'h10, 18'h00001, 1'b0, 18'h00000}, // R2 write base
    '{5'b11001, 2'b11, 3'b010, 8'h00, 18'h00002, 1'b0, 18'h00000}, // R5 beat1 -> 11
    '{5'b11001, 2'b11, 3'b010, 8'h00, 18'h00003, 1'b0, 18'h00000}, // beat2 -> 12
    '{5'b11001, 2'b11, 3'b010, 8'h00, 18'h00004, 1'b0, 18'h00000}, // beat3 -> 13
    '{5'b10111, 2'b11, 3'b010, 8'h12, 18'h00000, 1'b1, 18'h00003}, // R2 read 12
    '{5'b11011, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h00004}, // R5 12^1=13
    '{5'b11011, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h00001}, // R5 12^2=10
    '{5'b11011, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h00002}, // R5 12^3=11
    '{5'b11011, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h00003}, // R5 wrap 12
    '{5'b11111, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h00003}, // R9 hold
    '{5'b10110, 2'b10, 3'b010, 8'h12, 18'h3FFFF, 1'b0, 18'h00000}, // R8 lane a only
    '{5'b11110, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b1, 18'h001FF}, // R8 no lane = read
    '{5'b01101, 2'b11, 3'b010, 8'h13, 18'h2AAAA, 1'b1, 18'h00004}, // R7 adsp reads
    '{5'b11101, 2'b11, 3'b010, 8'h00, 18'h15555, 1'b0, 18'h00000}, // R9 write held addr
    '{5'b10111, 2'b11, 3'b010, 8'h13, 18'h00000, 1'b1, 18'h15555}, // R9 check 13
    '{5'b01111, 2'b11, 3'b110, 8'h10, 18'h00000, 1'b1, 18'h15555}, // R3 adsp blocked
    '{5'b10101, 2'b11, 3'b000, 8'h10, 18'h00000, 1'b0, 18'h00000}, // R4 standby
    '{5'b11011, 2'b11, 3'b010, 8'h00, 18'h00000, 1'b0, 18'h00000}, // R4 still deselected
    '{5'b10111, 2'b11, 3'b010, 8'h10, 18'h00000, 1'b1, 18'h00001}, // R4 no write at 10
    '{5'b00101, 2'b11, 3'b010, 8'h11, 18'h3FFFF, 1'b1, 18'h00002}  // R3 adsp priority
  };

  task automatic cyc(input logic [4:0] ctl, input logic [1:0] bw, input logic [2:0] ce,
                     input logic [7:0] a, input logic [17:0] d);
    {adsp_n_i, adsc_n_i, adv_n_i, gwe_n_i, bwe_n_i} = ctl;
    bw_n_i = bw;
    {ce_n_i, ce1_i, ce2_n_i} = ce;
    addr_i = a;
    din_i  = d;
    @(posedge clk_i);
    #5;
  endtask

  task automatic chk(input string req, input logic exp_oe, input logic [17:0] exp_d);
    checks++;
    if (dout_oe_o !== exp_oe || (exp_oe && dout_o !== exp_d)) begin
      failures++;
      $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h", req, dout_oe_o, dout_o, exp_oe, exp_d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #5;
    chk("R1 in reset", 1'b0, 18'h0);
    rst_ni = 1'b1;
    cyc(5'b11011, 2'b11, 3'b010, 8'h00, 18'h0);
    chk("R1 deselected after reset", 1'b0, 18'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].ctl, VEC[i].bw, VEC[i].ce, VEC[i].addr, VEC[i].din);
      chk($sformatf("vector %0d", i), VEC[i].exp_oe, VEC[i].exp_do);
    end

    // R6 linear order from 0x12: 12,13,10,11
    order_xor_i = 1'b0;
    cyc(5'b10111, 2'b11, 3'b010, 8'h12, 18'h0); chk("R6 beat0", 1'b1, 18'h001FF);
    cyc(5'b11011, 2'b11, 3'b010, 8'h00, 18'h0); chk("R6 beat1", 1'b1, 18'h15555);
    cyc(5'b11011, 2'b11, 3'b010, 8'h00, 18'h0); chk("R6 beat2", 1'b1, 18'h00001);
    cyc(5'b11011, 2'b11, 3'b010, 8'h00, 18'h0); chk("R6 beat3", 1'b1, 18'h00002);

    // R10 output enable without a clock edge
    #2 oe_n_i = 1'b1;
    #1 chk("R10 oe off", 1'b0, 18'h0);
    oe_n_i = 1'b0;
    #1 chk("R10 oe on", 1'b1, 18'h00002);
    @(posedge clk_i); #5;

    // R12 sleep
    order_xor_i = 1'b1;
    cyc(5'b10111, 2'b11, 3'b010, 8'h10, 18'h0); chk("R12 base read", 1'b1, 18'h00001);
    sleep_i = 1'b1;
    cyc(5'b11001, 2'b11, 3'b010, 8'h00, 18'h3FFFF); chk("R12 sleep adv write", 1'b0, 18'h0);
    cyc(5'b10101, 2'b11, 3'b010, 8'h30, 18'h3FFFF); chk("R12 sleep strobe", 1'b0, 18'h0);
    sleep_i = 1'b0;
    cyc(5'b11011, 2'b11, 3'b010, 8'h00, 18'h0); chk("R12 resume beat1", 1'b1, 18'h00002);
    cyc(5'b10111, 2'b11, 3'b010, 8'h10, 18'h0); chk("R12 contents kept", 1'b1, 18'h00001);

    // R8 lane b only on controller-strobe first cycle
    cyc(5'b10110, 2'b01, 3'b010, 8'h12, 18'h3FFFF); chk("R8 lane b write", 1'b0, 18'h0);
    cyc(5'b10111, 2'b11, 3'b010, 8'h12, 18'h0);     chk("R8 both lanes", 1'b1, 18'h3FFFF);

    // R11 pipelined latency
    pipe_i = 1'b1;
    cyc(5'b10111, 2'b11, 3'b000, 8'h00, 18'h0);
    cyc(5'b10111, 2'b11, 3'b000, 8'h00, 18'h0);
    chk("R11 flushed", 1'b0, 18'h0);
    cyc(5'b10111, 2'b11, 3'b010, 8'h13, 18'h0); chk("R11 first edge", 1'b0, 18'h0);
    cyc(5'b10111, 2'b11, 3'b000, 8'h00, 18'h0); chk("R11 second edge", 1'b1, 18'h15555);
    cyc(5'b10111, 2'b11, 3'b000, 8'h00, 18'h0); chk("R11 drained", 1'b0, 18'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule